// File: doc/BRIEF.md
# Three-Channel Watchdog Timer

This block holds three watchdog channels behind one small 32-bit register window. Every channel owns an up-counter that advances on a reference tick, and a bite threshold. It also has a control word whose reset-enable bit arms the channel. Once armed, a channel requests a reset for as long as its count is at or above the bite threshold. Software keeps a channel alive by writing a fresh value, usually zero, into its counter. Any value may be loaded, so the counter can also be preset.

The channels are not identical. Channel 0 drives a recovery-mode reset request of its own. It also has a second threshold, the bark level, together with an interrupt enable and a sticky status flag, which raise an interrupt ahead of the bite. Channels 1 and 2 share one normal system-reset request line and have no bark or interrupt logic. Loading a zero threshold and a zero count into an armed channel gives an immediate reset request, which a system can use as a forced restart.

The bus has no handshake. A write takes effect at the clock edge where it is presented, and read data is a combinational function of the address and the stored state.

Top module: `wdt_triplet`

## Requirements
- R1: A synchronous active-low reset clears every count, threshold and control bit. After reset all mapped registers read 0 and all three outputs are low.
- R2: Each counter is CNT_W bits wide. It advances by exactly one on every clock edge where `tick` is high and wraps from its maximum value to 0.
- R3: A bus write to a counter loads the written value, and it takes priority over an increment at the same edge.
- R4: Channel n occupies byte offsets 0x10*n to 0x10*n+0xC: +0x0 count, +0x4 bite, +0x8 bark (channel 0 only), +0xC control. Control bit 2 is reset enable, bit 0 is interrupt enable and bit 1 is interrupt status. Written values read back, and bits above CNT_W read as 0.
- R5: `rst_recovery_req` follows channel 0 alone. `rst_system_req` is the OR of channels 1 and 2. Each request is visible in the cycle after the write that arms it.
- R6: An armed channel requests reset exactly when count >= bite, so equality counts as expired.
- R7: On channel 0 the status bit sets one cycle after interrupt enable is high and count >= bark. It stays set after the condition ends. `irq` is high only while both enable and status are set. Clearing the enable hides the interrupt but keeps the status bit.
- R8: Writing control with bit 1 = 1 clears the status bit unless the set condition holds at the same edge, in which case the status bit stays set. Software cannot set the status bit.
- R9: Channels 1 and 2 have no bark register or interrupt. Their control bits 0 and 1 read 0, offsets 0x18 and 0x28 read 0, and writes to those offsets change nothing.
- R10: Offsets 0x30 to 0x3C and any offset with nonzero low two bits read 0, and writes to them change no register.
- R11: With reset enable set, a bite of 0 with a count of 0 produces a reset request at once.
- R12: Writing 0 to a control word drops that channel's reset request in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Reference tick; each high cycle advances all counters |
| wr_en | input | 1 | Write strobe for the register bus |
| addr | input | 6 | Byte address within the register window |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Channel 0 bark interrupt |
| rst_recovery_req | output | 1 | Recovery-mode reset request from channel 0 |
| rst_system_req | output | 1 | Normal reset request from channel 1 or 2 |

## Verification
The bench builds the block with CNT_W = 8. This shrinks each counter to 256 states, so a sweep can load every value and confirm both the single-tick increment and the wrap to zero. It also reaches every count on both sides of a fixed bite threshold, which checks the greater-or-equal comparison at its boundary. The narrow width also makes the truncation of upper write bits visible on readback. The bark, status and clear interactions run as short directed sequences on channel 0, timed to the cycle after each write.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
// Package wdt_pkg
// Shared constants for the three-channel watchdog: window geometry,
// register field selectors (address bits [3:2]) and control bit positions.
package wdt_pkg;
    localparam int NUM_CH = 3;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 6;
    localparam int SLOT_W = ADDR_W - 4;

    localparam logic [1:0] F_COUNT = 2'd0;
    localparam logic [1:0] F_BITE  = 2'd1;
    localparam logic [1:0] F_BARK  = 2'd2;
    localparam logic [1:0] F_CTRL  = 2'd3;

    localparam int CB_IRQ_EN = 0;
    localparam int CB_STATUS = 1;
    localparam int CB_RST_EN = 2;
endpackage

// File: rtl/wdt_channel.sv
`timescale 1ns/1ps
// Module wdt_channel
// One watchdog channel: a loadable up-counter, a bite threshold, a reset
// enable and, when HAS_BARK is set, a bark threshold with an interrupt
// enable and a sticky status flag. It decodes its own slot of the window.
// Assumes CNT_W <= 32 and that CH_IDX fits in the slot field.
module wdt_channel
    import wdt_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int CH_IDX   = 0,
    parameter bit HAS_BARK = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  bite_q,
    output logic [CNT_W-1:0]  bark_q,
    output logic [2:0]        ctrl_rd,
    output logic              rst_req,
    output logic              irq
);
    localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(CH_IDX);

    logic sel, wr_cnt, wr_bite, wr_ctrl;
    logic rst_en_q, irq_en_q, status_q;

    // Address decode for this channel's slot (word aligned only).
    assign sel     = wr_en && (addr[1:0] == 2'b00) && (addr[ADDR_W-1:4] == MY_SLOT);
    assign wr_cnt  = sel && (addr[3:2] == F_COUNT);
    assign wr_bite = sel && (addr[3:2] == F_BITE);
    assign wr_ctrl = sel && (addr[3:2] == F_CTRL);

    // Counter: bus load wins over the tick increment.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (wr_cnt) cnt_q <= wr_data[CNT_W-1:0];
        else if (tick)   cnt_q <= cnt_q + 1'b1;
    end

    // Bite threshold register.
    always_ff @(posedge clk) begin
        if (!rst_n)       bite_q <= '0;
        else if (wr_bite) bite_q <= wr_data[CNT_W-1:0];
    end

    // Reset-enable control bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       rst_en_q <= 1'b0;
        else if (wr_ctrl) rst_en_q <= wr_data[CB_RST_EN];
    end

    generate
        if (HAS_BARK) begin : g_bark
            logic wr_bark, bark_hit;
            assign wr_bark  = sel && (addr[3:2] == F_BARK);
            assign bark_hit = irq_en_q && (cnt_q >= bark_q);

            // Bark threshold register.
            always_ff @(posedge clk) begin
                if (!rst_n)       bark_q <= '0;
                else if (wr_bark) bark_q <= wr_data[CNT_W-1:0];
            end

            // Interrupt enable bit.
            always_ff @(posedge clk) begin
                if (!rst_n)       irq_en_q <= 1'b0;
                else if (wr_ctrl) irq_en_q <= wr_data[CB_IRQ_EN];
            end

            // Sticky status: hardware set beats a write-one clear.
            always_ff @(posedge clk) begin
                if (!rst_n)                           status_q <= 1'b0;
                else if (bark_hit)                    status_q <= 1'b1;
                else if (wr_ctrl && wr_data[CB_STATUS]) status_q <= 1'b0;
            end
        end else begin : g_plain
            assign bark_q   = '0;
            assign irq_en_q = 1'b0;
            assign status_q = 1'b0;
        end
    endgenerate

    // Outputs: request on expiry while armed, masked interrupt.
    assign rst_req = rst_en_q && (cnt_q >= bite_q);
    assign irq     = irq_en_q && status_q;
    assign ctrl_rd = {rst_en_q, status_q, irq_en_q};
endmodule

// File: rtl/wdt_readmux.sv
`timescale 1ns/1ps
// Module wdt_readmux
// Combinational read path: selects one channel field by address and
// zero-extends it to the bus width. Unmapped or misaligned offsets read 0.
// Assumes CNT_W <= 32; channels without bark logic present a zero bark.
module wdt_readmux
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic [ADDR_W-1:0]            addr,
    input  logic [NUM_CH-1:0][CNT_W-1:0] cnt_all,
    input  logic [NUM_CH-1:0][CNT_W-1:0] bite_all,
    input  logic [NUM_CH-1:0][CNT_W-1:0] bark_all,
    input  logic [NUM_CH-1:0][2:0]       ctrl_all,
    output logic [BUS_W-1:0]             rd_data
);
    // Select the addressed field of the addressed channel.
    always_comb begin
        rd_data = '0;
        if (addr[1:0] == 2'b00) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (addr[ADDR_W-1:4] == SLOT_W'(i)) begin
                    case (addr[3:2])
                        F_COUNT: rd_data = BUS_W'(cnt_all[i]);
                        F_BITE:  rd_data = BUS_W'(bite_all[i]);
                        F_BARK:  rd_data = BUS_W'(bark_all[i]);
                        default: rd_data = BUS_W'(ctrl_all[i]);
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/wdt_triplet.sv
`timescale 1ns/1ps
// Module wdt_triplet
// Three watchdog channels in one register window. Channel 0 carries the
// bark interrupt and the recovery reset request; channels 1 and 2 share
// the system reset request. Assumes a single clock with tick as enable.
module wdt_triplet
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [BUS_W-1:0]  rd_data,
    output logic              irq,
    output logic              rst_recovery_req,
    output logic              rst_system_req
);
    logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt, ch_bite, ch_bark;
    logic [NUM_CH-1:0][2:0]       ch_ctrl;
    logic [NUM_CH-1:0]            ch_rst, ch_irq;

    // Channel instances; only channel 0 gets bark logic.
    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            wdt_channel #(
                .CNT_W   (CNT_W),
                .CH_IDX  (g),
                .HAS_BARK(g == 0)
            ) ch_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .tick   (tick),
                .wr_en  (wr_en),
                .addr   (addr),
                .wr_data(wr_data),
                .cnt_q  (ch_cnt[g]),
                .bite_q (ch_bite[g]),
                .bark_q (ch_bark[g]),
                .ctrl_rd(ch_ctrl[g]),
                .rst_req(ch_rst[g]),
                .irq    (ch_irq[g])
            );
        end
    endgenerate

    // Read path.
    wdt_readmux #(.CNT_W(CNT_W)) rd_i (
        .addr    (addr),
        .cnt_all (ch_cnt),
        .bite_all(ch_bite),
        .bark_all(ch_bark),
        .ctrl_all(ch_ctrl),
        .rd_data (rd_data)
    );

    // Output routing: recovery from channel 0, system from 1 or 2.
    assign rst_recovery_req = ch_rst[0];
    assign rst_system_req   = ch_rst[1] | ch_rst[2];
    assign irq              = |ch_irq;
endmodule

// File: rtl/wdt_checker.sv
`timescale 1ns/1ps
// Module wdt_checker
// Concurrent properties for wdt_triplet, attached by bind below.
// Observes bus ports, outputs, counters and control bits.
module wdt_checker
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        tick,
    input logic                        wr_en,
    input logic [ADDR_W-1:0]           addr,
    input logic [BUS_W-1:0]            wr_data,
    input logic                        irq,
    input logic                        rst_recovery_req,
    input logic                        rst_system_req,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt_q,
    input logic [NUM_CH-1:0]           rst_en,
    input logic [1:0]                  irq_ctl
);
    localparam logic [ADDR_W-1:0] CTRL0_ADDR = ADDR_W'(12);

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_cnt
            localparam logic [ADDR_W-1:0] CNT_ADDR = ADDR_W'(16 * g);

            // R2: an un-written counter steps by one on a tick
            p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(tick) && !($past(wr_en) && $past(addr) == CNT_ADDR))
                |-> cnt_q[g] == CNT_W'($past(cnt_q[g]) + 1'b1));

            // R2: no tick and no write leaves the counter unchanged
            p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && !$past(tick) && !($past(wr_en) && $past(addr) == CNT_ADDR))
                |-> $stable(cnt_q[g]));

            // R3: a bus load wins over the increment
            p_load_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(wr_en) && $past(addr) == CNT_ADDR)
                |-> cnt_q[g] == $past(wr_data[CNT_W-1:0]));
        end
    endgenerate

    // R5: recovery request only from an armed channel 0
    p_rec_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_recovery_req |-> rst_en[0]);

    // R5: system request only from an armed channel 1 or 2
    p_sys_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_system_req |-> (rst_en[1] || rst_en[2]));

    // R7: interrupt never without the status flag
    p_irq_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_ctl[1]);

    // R7: status stays set unless a clear write arrived
    p_status_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_ctl[1]) && !($past(wr_en) && $past(addr) == CTRL0_ADDR && $past(wr_data[1])))
        |-> irq_ctl[1]);

    // R8: status cannot rise while the enable was low
    p_status_no_sw_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(irq_ctl[1]) && !$past(irq_ctl[0])) |-> !irq_ctl[1]);
endmodule

bind wdt_triplet wdt_checker #(.CNT_W(CNT_W)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .tick            (tick),
    .wr_en           (wr_en),
    .addr            (addr),
    .wr_data         (wr_data),
    .irq             (irq),
    .rst_recovery_req(rst_recovery_req),
    .rst_system_req  (rst_system_req),
    .cnt_q           (ch_cnt),
    .rst_en          ({ch_ctrl[2][2], ch_ctrl[1][2], ch_ctrl[0][2]}),
    .irq_ctl         (ch_ctrl[0][1:0])
);

// File: tb/wdt_triplet_tb_top.sv
`timescale 1ns/1ps
// Bench for wdt_triplet with 8-bit counters: sweeps every counter value
// for increment/wrap and threshold comparison, plus directed sequences.
module wdt_triplet_tb_top;
    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq, rst_recovery_req, rst_system_req;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    wdt_triplet #(.CNT_W(CW)) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick            (tick),
        .wr_en           (wr_en),
        .addr            (addr),
        .wr_data         (wr_data),
        .rd_data         (rd_data),
        .irq             (irq),
        .rst_recovery_req(rst_recovery_req),
        .rst_system_req  (rst_system_req)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string req);
        addr = a;
        #1;
        chk(rd_data, exp, req);
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic outs_low(input string req);
        chk({29'd0, irq, rst_recovery_req, rst_system_req}, 32'd0, req);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: everything reads 0 after reset
        for (int a = 0; a < 64; a += 4) rd_chk(6'(a), 32'd0, "R1");
        outs_low("R1");

        // R2: every value increments by one, wrapping at 0xFF
        for (int v = 0; v < 256; v++) begin
            bus_wr(6'h00, 32'(v));
            pulse_tick();
            rd_chk(6'h00, 32'((v + 1) & 8'hFF), "R2");
        end
        bus_wr(6'h10, 32'hFC);
        for (int k = 0; k < 6; k++) pulse_tick();
        rd_chk(6'h10, 32'h02, "R2");

        // R3: load beats increment at the same edge
        @(negedge clk);
        addr = 6'h10; wr_data = 32'h77; wr_en = 1'b1; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        rd_chk(6'h10, 32'h77, "R3");

        // R4: readback and truncation above CNT_W
        bus_wr(6'h04, 32'h1234565A); rd_chk(6'h04, 32'h5A, "R4");
        bus_wr(6'h08, 32'hA5);       rd_chk(6'h08, 32'hA5, "R4");
        bus_wr(6'h14, 32'h33);       rd_chk(6'h14, 32'h33, "R4");
        bus_wr(6'h24, 32'h44);       rd_chk(6'h24, 32'h44, "R4");
        bus_wr(6'h20, 32'hFFFFFF12); rd_chk(6'h20, 32'h12, "R4");
        bus_wr(6'h0C, 32'h4);        rd_chk(6'h0C, 32'h4, "R4");
        bus_wr(6'h0C, 32'h0);

        // R6: count >= bite sweep on channel 0, routed to recovery (R5)
        bus_wr(6'h04, 32'h80);
        bus_wr(6'h0C, 32'h4);
        for (int v = 0; v < 256; v++) begin
            bus_wr(6'h00, 32'(v));
            chk({31'd0, rst_recovery_req}, {31'd0, v >= 128}, "R6");
        end
        chk({31'd0, rst_system_req}, 32'd0, "R5");
        // R12: control write of 0 drops the request
        bus_wr(6'h0C, 32'h0);
        chk({31'd0, rst_recovery_req}, 32'd0, "R12");

        // R5: channel 1 drives the system request only
        bus_wr(6'h14, 32'd10);
        bus_wr(6'h10, 32'd10);
        chk({31'd0, rst_system_req}, 32'd0, "R5");
        bus_wr(6'h1C, 32'h4);
        chk({30'd0, rst_system_req, rst_recovery_req}, 32'h2, "R5");
        bus_wr(6'h1C, 32'h0);
        chk({31'd0, rst_system_req}, 32'd0, "R12");

        // R6: channel 2 expires exactly at equality after a tick
        bus_wr(6'h24, 32'h20);
        bus_wr(6'h20, 32'h1F);
        bus_wr(6'h2C, 32'h4);
        chk({31'd0, rst_system_req}, 32'd0, "R6");
        pulse_tick();
        chk({31'd0, rst_system_req}, 32'd1, "R6");
        bus_wr(6'h2C, 32'h0);

        // R11: zero bite with zero count requests at once
        bus_wr(6'h14, 32'h90);
        bus_wr(6'h10, 32'h0);
        bus_wr(6'h1C, 32'h4);
        chk({31'd0, rst_system_req}, 32'd0, "R11");
        bus_wr(6'h14, 32'h0);
        chk({31'd0, rst_system_req}, 32'd1, "R11");
        bus_wr(6'h1C, 32'h0);

        // R7: bark interrupt timing, stickiness and masking
        bus_wr(6'h08, 32'd3);
        bus_wr(6'h00, 32'd0);
        bus_wr(6'h0C, 32'h1);
        chk({31'd0, irq}, 32'd0, "R7");
        bus_wr(6'h00, 32'd3);
        chk({31'd0, irq}, 32'd0, "R7");
        @(negedge clk);
        chk({31'd0, irq}, 32'd1, "R7");
        rd_chk(6'h0C, 32'h3, "R7");
        bus_wr(6'h00, 32'd0);
        @(negedge clk);
        rd_chk(6'h0C, 32'h3, "R7");
        bus_wr(6'h0C, 32'h0);
        chk({31'd0, irq}, 32'd0, "R7");
        rd_chk(6'h0C, 32'h2, "R7");

        // R8: clear, no software set, and set wins over clear
        bus_wr(6'h0C, 32'h2);
        rd_chk(6'h0C, 32'h0, "R8");
        bus_wr(6'h0C, 32'h3);
        rd_chk(6'h0C, 32'h1, "R8");
        chk({31'd0, irq}, 32'd0, "R8");
        bus_wr(6'h00, 32'd3);
        @(negedge clk);
        rd_chk(6'h0C, 32'h3, "R8");
        bus_wr(6'h0C, 32'h3);
        rd_chk(6'h0C, 32'h3, "R8");
        bus_wr(6'h00, 32'd0);
        bus_wr(6'h0C, 32'h2);
        rd_chk(6'h0C, 32'h0, "R8");
        chk({31'd0, irq}, 32'd0, "R8");

        // R9: channels 1 and 2 have no interrupt bits or bark register
        bus_wr(6'h1C, 32'hFFFFFFFF);
        rd_chk(6'h1C, 32'h4, "R9");
        chk({31'd0, irq}, 32'd0, "R9");
        bus_wr(6'h1C, 32'h0);
        bus_wr(6'h18, 32'hAB);
        rd_chk(6'h18, 32'h0, "R9");
        bus_wr(6'h28, 32'hCD);
        rd_chk(6'h28, 32'h0, "R9");
        rd_chk(6'h10, 32'h0, "R9");
        rd_chk(6'h14, 32'h0, "R9");

        // R10: unmapped and misaligned offsets
        bus_wr(6'h30, 32'h99);
        bus_wr(6'h01, 32'h99);
        rd_chk(6'h00, 32'h0, "R10");
        rd_chk(6'h30, 32'h0, "R10");
        rd_chk(6'h3C, 32'h0, "R10");
        rd_chk(6'h01, 32'h0, "R10");
        rd_chk(6'h2D, 32'h0, "R10");

        // R1: reset in mid-operation clears state and outputs
        bus_wr(6'h00, 32'h55);
        bus_wr(6'h1C, 32'h4);
        chk({31'd0, rst_system_req}, 32'd1, "R1");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        outs_low("R1");
        rd_chk(6'h00, 32'h0, "R1");
        rd_chk(6'h1C, 32'h0, "R1");
        rd_chk(6'h08, 32'h0, "R1");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule